// File: doc/BRIEF.md
# PHY Management Access Controller

This block sits between a host register port and the management side of an Ethernet PHY. Software fills a control word with a PHY address, a register number and a direction flag, and sets the in-use bit to launch an access. For a write, the value comes from a data register loaded beforehand. For a read, the returned value lands in that same data register. The block drives a request to a PHY-side serialiser and holds it until a response arrives. It gives up after a fixed number of cycles when nothing answers. It clears in-use when the access ends.

Failures raise a sticky error bit, and a link-change event from the PHY side raises a second sticky bit. Software clears either bit by writing one to it. Software can cancel a pending access by writing in-use again while the block is busy. A separate register holds the management clock divider and enable for the serialiser. Host reads are combinational from the register address.

Top module: `mii_mgmt`

## Requirements
- R1: After reset, the control, data, status and clock-setting registers all read as zero and no request is driven.
- R2: The control word (host offset 0) has the register number in bits 4:0, the PHY address from bit 5, the write flag in bit 15 and in-use in bit 16. When the block is idle, a write to this word is read back unchanged. With bit 16 clear, no access starts.
- R3: A read access holds the request until the PHY response. In-use then reads 0, and the data register (offset 1) holds the returned value. In-use stays high for exactly as many cycles as the PHY takes to answer.
- R4: A write access sends the data register value to the addressed PHY register. The response error flag is ignored for writes.
- R5: A read answered with the error flag sets status bit 0 (offset 2) and leaves the data register unchanged.
- R6: An access with no response ends after TIMEOUT_CYC cycles of in-use and sets status bit 0.
- R7: Writing ones to status bits 3:0 clears the set bits. Writing zeros leaves them unchanged.
- R8: Writing the control word with bit 16 set while busy aborts the access on that edge. The data register, the status register and the PHY register contents are left untouched.
- R9: A pulse on link_evt_i sets status bit 3.
- R10: The clock-setting register (offset 3) holds the divider in bits 7:0 and the enable in bit 8. Both are driven to the serialiser.
- R11: While busy, writes to the data register and control writes without bit 16 are ignored. The request fields stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_we_i | input | 1 | Host register write strobe |
| host_addr_i | input | 2 | Host register index |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data (combinational) |
| link_evt_i | input | 1 | Link-change event pulse |
| req_o | output | 1 | Management access request, held until the end of the access |
| req_we_o | output | 1 | Request is a write |
| req_phy_o | output | PHY_AW | Target PHY address |
| req_reg_o | output | REG_AW | Target register number |
| req_wdata_o | output | DW | Write value |
| rsp_valid_i | input | 1 | PHY-side response strobe |
| rsp_err_i | input | 1 | Response error flag |
| rsp_rdata_i | input | DW | Read value |
| abort_o | output | 1 | Pulse telling the serialiser the access was cancelled |
| mdc_div_o | output | 8 | Management clock divider |
| mdc_en_o | output | 1 | Management clock enable |

## Verification
A stuck busy state shows at once: in-use reads high for a cycle count that differs from the responder's latency, or from TIMEOUT_CYC for absent addresses. A wrong field capture or a lost data update shows on the next read-back as a value that differs from the responder model. A wrong status update shows on the status read in the cycle after the terminating edge.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;
  localparam int HOST_AW = 2;
  localparam int HOST_DW = 32;
  typedef enum logic [HOST_AW-1:0] {
    REG_CTRL = 2'd0,
    REG_DATA = 2'd1,
    REG_STAT = 2'd2,
    REG_CLK  = 2'd3
  } host_reg_e;
  localparam int CTRL_PHY_LSB = 5;
  localparam int CTRL_WR_BIT  = 15;
  localparam int CTRL_USE_BIT = 16;
  localparam int STAT_ERR_BIT = 0;
  localparam int STAT_LNK_BIT = 3;
  localparam int CLK_DIV_W    = 8;
  localparam int CLK_EN_BIT   = 8;
endpackage

// File: rtl/mii_mgmt_seq.sv
module mii_mgmt_seq #(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  input  logic is_write_i,
  input  logic rsp_valid_i,
  input  logic rsp_err_i,
  output logic busy_o,
  output logic rd_ok_o,
  output logic err_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          expire, rsp;

  assign expire  = busy_q && !rsp_valid_i && (cnt_q == CW'(TIMEOUT_CYC - 1));
  assign rsp     = busy_q && rsp_valid_i && !abort_i;
  assign rd_ok_o = rsp && !is_write_i && !rsp_err_i;
  assign err_o   = (rsp && !is_write_i && rsp_err_i) || (expire && !abort_i);
  assign busy_o  = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (abort_i || rsp_valid_i || expire) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end
endmodule

// File: rtl/mii_mgmt_stat.sv
module mii_mgmt_stat (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_err_i,
  input  logic       set_lnk_i,
  input  logic       clr_i,
  input  logic [3:0] clr_mask_i,
  output logic [3:0] stat_o
);
  import mii_mgmt_pkg::*;

  logic err_q, lnk_q;

  // a set in the same cycle as a clear wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
      lnk_q <= 1'b0;
    end else begin
      if (set_err_i) err_q <= 1'b1;
      else if (clr_i && clr_mask_i[STAT_ERR_BIT]) err_q <= 1'b0;
      if (set_lnk_i) lnk_q <= 1'b1;
      else if (clr_i && clr_mask_i[STAT_LNK_BIT]) lnk_q <= 1'b0;
    end
  end

  always_comb begin
    stat_o = '0;
    stat_o[STAT_ERR_BIT] = err_q;
    stat_o[STAT_LNK_BIT] = lnk_q;
  end
endmodule

// File: rtl/mii_mgmt.sv
module mii_mgmt #(
  parameter int PHY_AW      = 5,
  parameter int REG_AW      = 5,
  parameter int DW          = 16,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [1:0]        host_addr_i,
  input  logic [31:0]       host_wdata_i,
  output logic [31:0]       host_rdata_o,
  input  logic              link_evt_i,
  output logic              req_o,
  output logic              req_we_o,
  output logic [PHY_AW-1:0] req_phy_o,
  output logic [REG_AW-1:0] req_reg_o,
  output logic [DW-1:0]     req_wdata_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_err_i,
  input  logic [DW-1:0]     rsp_rdata_i,
  output logic              abort_o,
  output logic [7:0]        mdc_div_o,
  output logic              mdc_en_o
);
  import mii_mgmt_pkg::*;

  localparam int CLK_W = CLK_EN_BIT + 1;

  logic              busy, rd_ok, set_err;
  logic              ctrl_we, data_we, stat_we, clk_we, start, abort;
  logic [REG_AW-1:0] reg_q;
  logic [PHY_AW-1:0] phy_q;
  logic              wr_q;
  logic [DW-1:0]     data_q;
  logic [CLK_W-1:0]  clk_q;
  logic [3:0]        stat;

  assign ctrl_we = host_we_i && (host_addr_i == REG_CTRL);
  assign data_we = host_we_i && (host_addr_i == REG_DATA) && !busy;
  assign stat_we = host_we_i && (host_addr_i == REG_STAT);
  assign clk_we  = host_we_i && (host_addr_i == REG_CLK);
  assign start   = ctrl_we && !busy && host_wdata_i[CTRL_USE_BIT];
  assign abort   = ctrl_we && busy && host_wdata_i[CTRL_USE_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q  <= '0;
      phy_q  <= '0;
      wr_q   <= 1'b0;
      data_q <= '0;
      clk_q  <= '0;
    end else begin
      if (ctrl_we && !busy) begin
        reg_q <= host_wdata_i[REG_AW-1:0];
        phy_q <= host_wdata_i[CTRL_PHY_LSB +: PHY_AW];
        wr_q  <= host_wdata_i[CTRL_WR_BIT];
      end
      if (rd_ok)        data_q <= rsp_rdata_i;
      else if (data_we) data_q <= host_wdata_i[DW-1:0];
      if (clk_we) clk_q <= host_wdata_i[CLK_W-1:0];
    end
  end

  mii_mgmt_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .abort_i    (abort),
    .is_write_i (wr_q),
    .rsp_valid_i(rsp_valid_i),
    .rsp_err_i  (rsp_err_i),
    .busy_o     (busy),
    .rd_ok_o    (rd_ok),
    .err_o      (set_err)
  );

  mii_mgmt_stat u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_err_i (set_err),
    .set_lnk_i (link_evt_i),
    .clr_i     (stat_we),
    .clr_mask_i(host_wdata_i[3:0]),
    .stat_o    (stat)
  );

  always_comb begin
    host_rdata_o = '0;
    unique case (host_addr_i)
      REG_CTRL: begin
        host_rdata_o[REG_AW-1:0]               = reg_q;
        host_rdata_o[CTRL_PHY_LSB +: PHY_AW]   = phy_q;
        host_rdata_o[CTRL_WR_BIT]              = wr_q;
        host_rdata_o[CTRL_USE_BIT]             = busy;
      end
      REG_DATA: host_rdata_o[DW-1:0]    = data_q;
      REG_STAT: host_rdata_o[3:0]       = stat;
      REG_CLK:  host_rdata_o[CLK_W-1:0] = clk_q;
      default:  host_rdata_o = '0;
    endcase
  end

  assign req_o       = busy;
  assign req_we_o    = wr_q;
  assign req_phy_o   = phy_q;
  assign req_reg_o   = reg_q;
  assign req_wdata_o = data_q;
  assign abort_o     = abort;
  assign mdc_div_o   = clk_q[CLK_DIV_W-1:0];
  assign mdc_en_o    = clk_q[CLK_EN_BIT];
endmodule

// File: rtl/mii_mgmt_chk.sv
module mii_mgmt_chk #(
  parameter int PHY_AW      = 5,
  parameter int REG_AW      = 5,
  parameter int TIMEOUT_CYC = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_we_i,
  input logic [1:0]        host_addr_i,
  input logic [31:0]       host_wdata_i,
  input logic              req_o,
  input logic              req_we_o,
  input logic [PHY_AW-1:0] req_phy_o,
  input logic [REG_AW-1:0] req_reg_o,
  input logic              rsp_valid_i,
  input logic              rsp_err_i,
  input logic              abort_o,
  input logic              stat_err
);
  localparam int CW = $clog2(TIMEOUT_CYC + 2);
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (req_o) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  // R8
  abort_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && host_addr_i == 2'd0 && host_wdata_i[16] && req_o) |=> !req_o);
  // R3
  rsp_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && rsp_valid_i) |=> !req_o);
  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> (!req_o || ($stable(req_phy_o) && $stable(req_reg_o) && $stable(req_we_o))));
  // R5
  rd_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && rsp_valid_i && rsp_err_i && !req_we_o && !abort_o) |=> stat_err);
  // R6
  timeout_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= CW'(TIMEOUT_CYC));
endmodule

bind mii_mgmt mii_mgmt_chk #(
  .PHY_AW(PHY_AW), .REG_AW(REG_AW), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .host_we_i   (host_we_i),
  .host_addr_i (host_addr_i),
  .host_wdata_i(host_wdata_i),
  .req_o       (req_o),
  .req_we_o    (req_we_o),
  .req_phy_o   (req_phy_o),
  .req_reg_o   (req_reg_o),
  .rsp_valid_i (rsp_valid_i),
  .rsp_err_i   (rsp_err_i),
  .abort_o     (abort_o),
  .stat_err    (stat[0])
);

// File: tb/mii_mgmt_tb.sv
module mii_mgmt_tb;
  localparam int TO = 64;

  logic clk = 0, rst_n = 0;
  logic we = 0;
  logic [1:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic link_evt = 0;
  logic req, req_we, abort;
  logic [4:0] req_phy, req_reg;
  logic [15:0] req_wdata, rsp_rdata;
  logic rsp_valid, rsp_err;
  logic [7:0] mdc_div;
  logic mdc_en;

  int ntests = 0, nfail = 0;
  logic [15:0] mem [32][32];
  int scnt;

  always #10 clk = ~clk;

  mii_mgmt #(.TIMEOUT_CYC(TO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(we), .host_addr_i(addr),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .link_evt_i(link_evt),
    .req_o(req), .req_we_o(req_we), .req_phy_o(req_phy), .req_reg_o(req_reg),
    .req_wdata_o(req_wdata), .rsp_valid_i(rsp_valid), .rsp_err_i(rsp_err),
    .rsp_rdata_i(rsp_rdata), .abort_o(abort), .mdc_div_o(mdc_div), .mdc_en_o(mdc_en));

  // PHY responder: present at addresses 1, 3, 6; latency 2+addr; reg 31 errors on reads
  function automatic bit present(input int p);
    return (p == 1 || p == 3 || p == 6);
  endfunction
  function automatic logic [15:0] init_val(input int p, input int r);
    return 16'(p * 4099 + r * 257 + 16'h1234);
  endfunction

  assign rsp_valid = req && present(int'(req_phy)) && (scnt == int'(req_phy) + 1);
  assign rsp_err   = rsp_valid && !req_we && (req_reg == 5'd31);
  assign rsp_rdata = mem[req_phy][req_reg];

  always @(posedge clk) begin
    if (!req || rsp_valid) scnt <= 0;
    else scnt <= scnt + 1;
    if (rsp_valid && req_we) mem[req_phy][req_reg] <= req_wdata;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; wdata = 0;
  endtask

  task automatic hr(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  function automatic logic [31:0] cw(input int p, input int r, input bit w, input bit go);
    return (go ? 32'h10000 : 0) | (w ? 32'h8000 : 0) | 32'(p << 5) | 32'(r);
  endfunction

  task automatic access(input int p, input int r, input bit w, input logic [15:0] wd, output int cyc);
    logic [31:0] v;
    if (w) hw(2'd1, {16'h0, wd});
    hw(2'd0, cw(p, r, w, 1));
    cyc = 0;
    forever begin
      hr(2'd0, v);
      if (!v[16]) break;
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    #4_000_000;
    nfail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int cyc;
    logic [15:0] last;
    for (int p = 0; p < 32; p++)
      for (int r = 0; r < 32; r++) mem[p][r] = init_val(p, r);
    scnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      hr(2'(a), v);
      check(v == 0, "R1 reset reg", v, 0);
    end
    check(req == 0, "R1 no request", 32'(req), 0);

    // R2 field readback without start
    hw(2'd0, cw(9, 17, 1, 0));
    hr(2'd0, v);
    check(v == cw(9, 17, 1, 0), "R2 ctrl readback", v, cw(9, 17, 1, 0));
    check(req == 0, "R2 no start", 32'(req), 0);

    // R3 read sweep over present PHYs
    for (int pi = 0; pi < 3; pi++) begin
      int p;
      p = (pi == 0) ? 1 : (pi == 1) ? 3 : 6;
      for (int r = 0; r < 31; r++) begin
        access(p, r, 0, 0, cyc);
        hr(2'd1, v);
        check(v == {16'h0, init_val(p, r)}, "R3 read data", v, {16'h0, init_val(p, r)});
        check(cyc == p + 2, "R3 busy cycles", cyc, p + 2);
      end
    end
    hr(2'd2, v);
    check(v == 0, "R3 no error", v, 0);

    // R4 writes then read back
    for (int r = 0; r < 8; r++) begin
      logic [15:0] val;
      val = 16'(16'hA000 + r * 97);
      access(3, r, 1, val, cyc);
      access(3, r, 0, 0, cyc);
      hr(2'd1, v);
      check(v == {16'h0, val}, "R4 write effect", v, {16'h0, val});
    end
    access(1, 31, 1, 16'h5A5A, cyc);
    check(mem[1][31] == 16'h5A5A, "R4 write reg31", 32'(mem[1][31]), 32'h5A5A);
    hr(2'd2, v);
    check(v[0] == 0, "R4 write err ignored", v, 0);

    // R5 read error keeps data
    access(1, 2, 0, 0, cyc);
    last = init_val(1, 2);
    access(6, 31, 0, 0, cyc);
    hr(2'd2, v);
    check(v == 32'h1, "R5 err bit", v, 1);
    hr(2'd1, v);
    check(v == {16'h0, last}, "R5 data kept", v, {16'h0, last});

    // R7 zero write keeps, ones clear
    hw(2'd2, 32'h0);
    hr(2'd2, v);
    check(v == 32'h1, "R7 zero no clear", v, 1);
    hw(2'd2, 32'hF);
    hr(2'd2, v);
    check(v == 0, "R7 w1c", v, 0);

    // R6 timeout on every empty address
    for (int p = 0; p < 32; p++) begin
      if (!present(p)) begin
        access(p, p, 0, 0, cyc);
        check(cyc == TO, "R6 timeout cycles", cyc, TO);
        hr(2'd2, v);
        check(v == 32'h1, "R6 err set", v, 1);
        hw(2'd2, 32'hF);
      end
    end

    // R8 abort a read and a write
    access(1, 5, 0, 0, cyc);
    last = init_val(1, 5);
    hw(2'd0, cw(6, 4, 0, 1));
    @(negedge clk);
    hw(2'd0, 32'h10000);
    hr(2'd0, v);
    check(v[16] == 0, "R8 abort clears busy", v, 0);
    hr(2'd1, v);
    check(v == {16'h0, last}, "R8 data kept", v, {16'h0, last});
    hr(2'd2, v);
    check(v == 0, "R8 no err", v, 0);
    hw(2'd1, 32'h0000_7777);
    hw(2'd0, cw(6, 9, 1, 1));
    hw(2'd0, 32'h10000);
    repeat (12) @(negedge clk);
    check(mem[6][9] == init_val(6, 9), "R8 write not applied", 32'(mem[6][9]), 32'(init_val(6, 9)));

    // R11 ignored writes while busy
    hw(2'd1, 32'h0000_1111);
    hw(2'd0, cw(6, 10, 1, 1));
    hw(2'd1, 32'h0000_2222);
    hw(2'd0, cw(3, 20, 0, 0));
    hr(2'd0, v2);
    check(v2 == cw(6, 10, 1, 1), "R11 fields held", v2, cw(6, 10, 1, 1));
    repeat (10) @(negedge clk);
    check(mem[6][10] == 16'h1111, "R11 data held", 32'(mem[6][10]), 32'h1111);

    // R9 link event
    @(negedge clk); link_evt = 1; @(negedge clk); link_evt = 0;
    hr(2'd2, v);
    check(v == 32'h8, "R9 link bit", v, 8);
    hw(2'd2, 32'hF);
    hr(2'd2, v);
    check(v == 0, "R9 link clear", v, 0);

    // R10 clock setting
    hw(2'd3, 32'h105);
    hr(2'd3, v);
    check(v == 32'h105, "R10 readback", v, 32'h105);
    check(mdc_div == 8'd5 && mdc_en == 1, "R10 outputs", {mdc_en, mdc_div}, 32'h105);

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule